// File: doc/BRIEF.md
# Eight-Bit Addressable Latch with Decoder Mode

This block keeps eight single-bit values. A 3-bit address picks one of them, and a single data input writes the picked bit. Two active-low controls choose one of four modes:

- **Addressable write:** the picked bit follows the data input.
- **Hold:** all eight bits keep their values.
- **Decode:** the block acts as a 3-to-8 demultiplexer. The picked output carries the data and every other output is forced low.
- **Clear:** every output is forced low.

The storage is level-sensitive and has no clock. A caller uses it as a serial-to-parallel register by writing one bit per address. Tying the data input high turns it into a plain 3-to-8 decoder. The address should only move while the block is in hold mode. If it moves during a write and several address bits change at once, a wrong bit can be picked for a moment.

Top module: `addr_latch8`

## Requirements
- R1: Address value n (0 to 7, binary, `sel_addr[0]` least significant) selects output bit `qout[n]`. Each output bit is active high and reflects one storage bit.
- R2: The mode is set by the two controls: `clear_n`=1 and `wr_en_n`=0 is addressable write; 1/1 is hold; 0/0 is decode; 0/1 is clear.
- R3: In addressable-write mode, `qout[sel_addr]` follows `din` transparently, with no clock. A change on `din` shows at once.
- R4: In addressable-write mode, every non-selected output keeps the value it had before.
- R5: In hold mode, all outputs keep their values whatever `din` and `sel_addr` do.
- R6: In decode mode, `qout[sel_addr]` equals `din` and all other outputs are 0.
- R7: In decode mode with `din`=1, exactly one output is high, and it is the addressed one.
- R8: In clear mode, all outputs are 0 for every address and data value.
- R9: When the block goes from decode or clear mode into hold mode, the stored bits keep the output values present at that change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clear_n | input | 1 | Active-low common clear / decode select |
| wr_en_n | input | 1 | Active-low write enable |
| sel_addr | input | 3 | Address of the selected bit |
| din | input | 1 | Single-bit data input |
| qout | output | 8 | Stored bits, active high |

## Verification
In addressable-write mode, the block is loaded one address at a time with an alternating pattern. Its complement then overwrites it, which shows whether each write reaches only its own bit. The data input is toggled with the address held still in write mode, which separates transparent following from edge capture. In hold mode, the data and address are swept, which would reveal any leaking write path. Decode mode is run at every address with data high and data low, followed by a move into hold, which separates forcing the other outputs low from merely holding them, and checks that the stored values match what was shown.

// File: rtl/addr_latch8_pkg.sv
package addr_latch8_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE  = 2'd0,
    MODE_HOLD   = 2'd1,
    MODE_DECODE = 2'd2,
    MODE_CLEAR  = 2'd3
  } lat_mode_e;
endpackage

// File: rtl/addr_latch8_ctrl.sv
module addr_latch8_ctrl
  import addr_latch8_pkg::*;
(
  input  logic      clear_n,
  input  logic      wr_en_n,
  output lat_mode_e mode
);
  always_comb begin
    unique case ({clear_n, wr_en_n})
      2'b10:   mode = MODE_WRITE;
      2'b11:   mode = MODE_HOLD;
      2'b00:   mode = MODE_DECODE;
      default: mode = MODE_CLEAR;
    endcase
  end
endmodule

// File: rtl/addr_latch8_dec.sv
module addr_latch8_dec #(
  parameter int AW = 3,
  localparam int NB = 1 << AW
) (
  input  logic [AW-1:0] addr,
  output logic [NB-1:0] onehot
);
  for (genvar i = 0; i < NB; i++) begin : g_sel
    assign onehot[i] = (addr == AW'(i));
  end

  always_comb begin
    // R1
    addr_onehot_chk: assert ($onehot(onehot));
  end
endmodule

// File: rtl/addr_latch8_cell.sv
module addr_latch8_cell (
  input  logic wr,
  input  logic val,
  output logic q
);
  always_latch begin
    if (wr) q = val;
  end
endmodule

// File: rtl/addr_latch8.sv
module addr_latch8
  import addr_latch8_pkg::*;
#(
  parameter int AW = 3,
  localparam int NB = 1 << AW
) (
  input  logic          clear_n,
  input  logic          wr_en_n,
  input  logic [AW-1:0] sel_addr,
  input  logic          din,
  output logic [NB-1:0] qout
);
  lat_mode_e       mode;
  logic [NB-1:0]   sel;
  logic [NB-1:0]   cell_wr;
  logic [NB-1:0]   cell_val;

  addr_latch8_ctrl u_ctrl (
    .clear_n (clear_n),
    .wr_en_n (wr_en_n),
    .mode    (mode)
  );

  addr_latch8_dec #(.AW(AW)) u_dec (
    .addr   (sel_addr),
    .onehot (sel)
  );

  for (genvar i = 0; i < NB; i++) begin : g_bit
    always_comb begin
      unique case (mode)
        MODE_WRITE:  cell_wr[i] = sel[i];
        MODE_HOLD:   cell_wr[i] = 1'b0;
        default:     cell_wr[i] = 1'b1;
      endcase
      cell_val[i] = (mode != MODE_CLEAR) && sel[i] && din;
    end

    addr_latch8_cell u_cell (
      .wr  (cell_wr[i]),
      .val (cell_val[i]),
      .q   (qout[i])
    );
  end

  always_comb begin
    if (mode == MODE_CLEAR) begin
      // R8
      clear_zero_chk: assert (qout == '0);
    end
    if (mode == MODE_DECODE) begin
      // R6
      decode_others_low_chk: assert ((qout & ~sel) == '0);
      // R6
      decode_addr_follow_chk: assert (qout[sel_addr] == din);
      // R7
      decode_single_high_chk: assert (!din || $countones(qout) == 1);
    end
    if (mode == MODE_WRITE) begin
      // R3
      write_follow_chk: assert (qout[sel_addr] == din);
    end
  end
endmodule

// File: tb/addr_latch8_bench.sv
module addr_latch8_bench;
  logic       clk;
  logic       clear_n, wr_en_n, din;
  logic [2:0] sel_addr;
  logic [7:0] qout;
  logic [7:0] model;
  int         total, bad;

  addr_latch8 u_addr_latch8 (
    .clear_n  (clear_n),
    .wr_en_n  (wr_en_n),
    .sel_addr (sel_addr),
    .din      (din),
    .qout     (qout)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Behavioural reference: updated from the mode rules, compared each cycle.
  task automatic step(input logic c, input logic w, input int a, input logic dv,
                      input string req);
    @(posedge clk);
    clear_n  = c;
    wr_en_n  = w;
    sel_addr = a[2:0];
    din      = dv;
    if (c && !w)       model[a] = dv;
    else if (!c && !w) begin model = 8'h00; model[a] = dv; end
    else if (!c && w)  model = 8'h00;
    @(negedge clk);
    total++;
    if (qout !== model) begin
      bad++;
      $display("FAIL %s: mode=%b%b addr=%0d din=%b actual=%h expected=%h",
               req, c, w, a, dv, qout, model);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0; model = 8'h00;
    clear_n = 1'b0; wr_en_n = 1'b1; sel_addr = 3'd0; din = 1'b0;
    // R8 reset state and clear mode over every address and data value
    for (int a = 0; a < 8; a++) begin
      step(1'b0, 1'b1, a, 1'b1, "R8");
      step(1'b0, 1'b1, a, 1'b0, "R8");
    end
    // R9 clear then hold keeps zeros
    step(1'b1, 1'b1, 0, 1'b1, "R9");
    // R1 R3 R4 load pattern 8'hA5 one address at a time, address moved in hold
    for (int a = 0; a < 8; a++) begin
      step(1'b1, 1'b1, a, 1'b0, "R5");
      step(1'b1, 1'b0, a, (8'hA5 >> a) & 1, "R4");
      step(1'b1, 1'b1, a, 1'b0, "R5");
    end
    // R4 overwrite with complement
    for (int a = 7; a >= 0; a--) begin
      step(1'b1, 1'b1, a, 1'b1, "R5");
      step(1'b1, 1'b0, a, (8'h5A >> a) & 1, "R1");
      step(1'b1, 1'b1, a, 1'b1, "R5");
    end
    // R3 transparency: toggle din with address fixed in write mode
    step(1'b1, 1'b1, 3, 1'b0, "R5");
    for (int k = 0; k < 6; k++) step(1'b1, 1'b0, 3, k[0], "R3");
    step(1'b1, 1'b1, 3, 1'b0, "R5");
    // R5 hold ignores din and address
    for (int a = 0; a < 8; a++) step(1'b1, 1'b1, a, a[0], "R5");
    // R6 R7 decode mode every address, din high and low
    for (int a = 0; a < 8; a++) begin
      step(1'b0, 1'b0, a, 1'b1, "R7");
      step(1'b0, 1'b0, a, 1'b0, "R6");
      step(1'b0, 1'b0, a, 1'b1, "R6");
    end
    // R9 decode -> hold keeps single high bit
    step(1'b1, 1'b1, 7, 1'b0, "R9");
    step(1'b1, 1'b1, 2, 1'b1, "R9");
    // R2 write after decode touches only addressed bit
    step(1'b1, 1'b0, 2, 1'b1, "R2");
    step(1'b1, 1'b1, 2, 1'b0, "R2");
    // R9 decode with din low -> hold keeps all zeros
    step(1'b0, 1'b0, 5, 1'b0, "R9");
    step(1'b1, 1'b1, 5, 1'b1, "R9");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule